// File: doc/BRIEF.md
# Configurable PLD Output Macrocell

This block is one output cell of a small sum-of-products programmable logic device. It receives a group of product terms from the AND array and shapes them into what one device pin needs: a drive value, a tri-state enable, and a feedback bit that goes back into the array. Two global mode bits shared by all cells and two bits of the cell's own select its configuration. The configuration can be a clocked register with a pin-driven enable, a combinatorial I/O whose enable comes from a product term, or a dedicated combinatorial output that is always driven.

The cell has four configurations, named by the enumeration `cell_cfg_e`. `CFG_REG_OUT` is a registered output. `CFG_REG_COMB` is a combinatorial I/O inside registered mode. `CFG_CPLX_IO` is a combinatorial I/O in complex mode. `CFG_SIMPLE_OUT` is a dedicated output in simple mode. The only sequential state is the one-bit macrocell register. It is loaded from the product-term sum, or from a preload value, on every rising clock edge, whatever the configuration. An active-low reset clears it at any time. Two position inputs tell the cell whether it is one of the two outermost cells or one of the two innermost cells of the device. Position decides whether the cell has a feedback path.

Top module: `olmc_cell`

## Requirements
- R1: Mode decode. `glb_arch`=1 with `glb_sync`=0 selects registered mode. `glb_arch`=1 with `glb_sync`=1 selects complex mode. `glb_arch`=0 selects simple mode, whatever the value of `glb_sync`.
- R2: In registered mode with `cell_io`=0, the register loads the OR of all eight terms `pterm[7:0]` on each rising clock edge, and `pin_out` shows the register. `pin_oe` is the inverse of `oe_n`. The register is clocked in every configuration.
- R3: In registered mode with `cell_io`=0, `fb_out` is the inverse of the register content.
- R4: In registered mode with `cell_io`=1, and for every cell in complex mode, the data is the OR of `pterm[7:1]`. `pin_oe` equals `pterm[0]`, and `fb_out` equals `pin_in`.
- R5: Polarity. With `cell_pol`=1, `pin_out` equals the data. With `cell_pol`=0, `pin_out` is the inverted data. This holds in every configuration.
- R6: In complex mode, an outermost cell (`edge_cell`=1) drives `fb_out` to 0.
- R7: In simple mode, `pin_oe` is 1 and the data is the OR of all eight terms. `fb_out` equals `adj_in`, the level of the neighbouring pin.
- R8: In simple mode, an innermost cell (`core_cell`=1) drives `fb_out` to 0.
- R9: When `preload_en`=1 at a rising clock edge, the register loads `preload_val` instead of the term sum.
- R10: While `rst_n`=0 the register holds 0, and the reset takes effect without waiting for a clock edge. A registered output then shows 0 with `cell_pol`=1 and 1 with `cell_pol`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock pin |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| glb_sync | input | 1 | Global mode bit: with `glb_arch`=1, 0 selects registered and 1 selects complex |
| glb_arch | input | 1 | Global mode bit: 0 selects simple mode |
| cell_io | input | 1 | Per-cell bit: in registered mode, 1 makes the cell a combinatorial I/O |
| cell_pol | input | 1 | Per-cell polarity: 1 is active high, 0 is active low |
| edge_cell | input | 1 | Cell is one of the two outermost cells |
| core_cell | input | 1 | Cell is one of the two innermost cells |
| pterm | input | 8 | Product terms from the AND array; bit 0 is the enable term |
| oe_n | input | 1 | Common output-enable pin, active low |
| pin_in | input | 1 | Level present on this cell's pin |
| adj_in | input | 1 | Level present on the neighbouring pin |
| preload_en | input | 1 | Synchronous preload strobe |
| preload_val | input | 1 | Value written by preload |
| pin_out | output | 1 | Value driven toward the pin |
| pin_oe | output | 1 | Tri-state enable for the pin |
| fb_out | output | 1 | Feedback to the AND array |

## Verification
Single-term patterns separate the eight-term sums from the seven-term sums. Asserting only `pterm[0]` yields 1 in registered-output and simple configurations, but in a combinatorial I/O it raises only the enable. Asserting only `pterm[7]` raises the data with the enable off. Each configuration is run with both polarities and both position flags, so a wrong inversion or a wrong feedback source shows up. Preload is driven against an opposing term sum, and reset is dropped between clock edges. A long randomized stretch then mixes mode changes with register activity, which shows that the register keeps loading while the cell is combinatorial.

// File: rtl/olmc_pkg.sv
package olmc_pkg;
    typedef enum logic [1:0] {
        CFG_REG_OUT    = 2'd0,
        CFG_REG_COMB   = 2'd1,
        CFG_CPLX_IO    = 2'd2,
        CFG_SIMPLE_OUT = 2'd3
    } cell_cfg_e;
endpackage

// File: rtl/olmc_decode.sv
module olmc_decode
    import olmc_pkg::*;
(
    input  logic      glb_sync,
    input  logic      glb_arch,
    input  logic      cell_io,
    output cell_cfg_e cfg
);
    always_comb begin
        unique case ({glb_sync, glb_arch})
            2'b01:   cfg = cell_io ? CFG_REG_COMB : CFG_REG_OUT;
            2'b11:   cfg = CFG_CPLX_IO;
            default: cfg = CFG_SIMPLE_OUT;
        endcase
    end
endmodule

// File: rtl/olmc_or.sv
module olmc_or #(
    parameter int N = 8
) (
    input  logic [N-1:0] terms,
    output logic         any_hit
);
    logic [N:0] chain;
    assign chain[0] = 1'b0;
    for (genvar gi = 0; gi < N; gi++) begin : g_or
        assign chain[gi+1] = chain[gi] | terms[gi];
    end
    assign any_hit = chain[N];
endmodule

// File: rtl/olmc_reg.sv
module olmc_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic load_val,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= 1'b0;
        else if (load) q <= load_val;
        else           q <= d;
    end
endmodule

// File: rtl/olmc_cell.sv
module olmc_cell
    import olmc_pkg::*;
#(
    parameter int NTERM = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             glb_sync,
    input  logic             glb_arch,
    input  logic             cell_io,
    input  logic             cell_pol,
    input  logic             edge_cell,
    input  logic             core_cell,
    input  logic [NTERM-1:0] pterm,
    input  logic             oe_n,
    input  logic             pin_in,
    input  logic             adj_in,
    input  logic             preload_en,
    input  logic             preload_val,
    output logic             pin_out,
    output logic             pin_oe,
    output logic             fb_out
);
    localparam int NDATA   = NTERM - 1;
    localparam int OE_TERM = 0;

    cell_cfg_e cfg;
    logic      sum_all;
    logic      sum_data;
    logic      reg_q;
    logic      data_lvl;

    olmc_decode u_dec (
        .glb_sync (glb_sync),
        .glb_arch (glb_arch),
        .cell_io  (cell_io),
        .cfg      (cfg)
    );

    olmc_or #(.N(NTERM)) u_sum_all (
        .terms   (pterm),
        .any_hit (sum_all)
    );

    olmc_or #(.N(NDATA)) u_sum_data (
        .terms   (pterm[NTERM-1:OE_TERM+1]),
        .any_hit (sum_data)
    );

    olmc_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (preload_en),
        .load_val (preload_val),
        .d        (sum_all),
        .q        (reg_q)
    );

    always_comb begin
        unique case (cfg)
            CFG_REG_OUT: begin
                data_lvl = reg_q;
                pin_oe   = ~oe_n;
                fb_out   = ~reg_q;
            end
            CFG_REG_COMB: begin
                data_lvl = sum_data;
                pin_oe   = pterm[OE_TERM];
                fb_out   = pin_in;
            end
            CFG_CPLX_IO: begin
                data_lvl = sum_data;
                pin_oe   = pterm[OE_TERM];
                fb_out   = edge_cell ? 1'b0 : pin_in;
            end
            CFG_SIMPLE_OUT: begin
                data_lvl = sum_all;
                pin_oe   = 1'b1;
                fb_out   = core_cell ? 1'b0 : adj_in;
            end
            default: begin
                data_lvl = 1'b0;
                pin_oe   = 1'b0;
                fb_out   = 1'b0;
            end
        endcase
    end

    assign pin_out = cell_pol ? data_lvl : ~data_lvl;
endmodule

// File: rtl/olmc_cell_chk.sv
module olmc_cell_chk
    import olmc_pkg::*;
#(
    parameter int NTERM = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             glb_sync,
    input logic             glb_arch,
    input logic             edge_cell,
    input logic             core_cell,
    input logic [NTERM-1:0] pterm,
    input logic             oe_n,
    input logic             pin_in,
    input logic             preload_en,
    input logic             preload_val,
    input logic             pin_oe,
    input logic             fb_out,
    input cell_cfg_e        cfg,
    input logic             reg_q
);
    // R1: mode decode
    a_r1_simple_decode: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_arch |-> cfg == CFG_SIMPLE_OUT);
    a_r1_complex_decode: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_arch && glb_sync) |-> cfg == CFG_CPLX_IO);
    // R2: register follows the full term sum
    a_r2_reg_load: assert property (@(posedge clk) disable iff (!rst_n)
        !preload_en |=> reg_q == $past(|pterm));
    a_r2_pin_enable: assert property (@(posedge clk) disable iff (!rst_n)
        cfg == CFG_REG_OUT |-> pin_oe == !oe_n);
    // R3: registered feedback
    a_r3_reg_fb: assert property (@(posedge clk) disable iff (!rst_n)
        cfg == CFG_REG_OUT |-> fb_out == !reg_q);
    // R4: term-driven enable and pin feedback
    a_r4_term_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg == CFG_REG_COMB || cfg == CFG_CPLX_IO) |-> pin_oe == pterm[0]);
    a_r4_pin_fb: assert property (@(posedge clk) disable iff (!rst_n)
        cfg == CFG_REG_COMB |-> fb_out == pin_in);
    // R6: outer cells in complex mode
    a_r6_edge_no_fb: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg == CFG_CPLX_IO && edge_cell) |-> !fb_out);
    // R7: simple mode always drives
    a_r7_always_on: assert property (@(posedge clk) disable iff (!rst_n)
        cfg == CFG_SIMPLE_OUT |-> pin_oe);
    // R8: inner cells in simple mode
    a_r8_core_no_fb: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg == CFG_SIMPLE_OUT && core_cell) |-> !fb_out);
    // R9: preload wins over the terms
    a_r9_preload: assert property (@(posedge clk) disable iff (!rst_n)
        preload_en |=> reg_q == $past(preload_val));
endmodule

bind olmc_cell olmc_cell_chk #(.NTERM(NTERM)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .glb_sync    (glb_sync),
    .glb_arch    (glb_arch),
    .edge_cell   (edge_cell),
    .core_cell   (core_cell),
    .pterm       (pterm),
    .oe_n        (oe_n),
    .pin_in      (pin_in),
    .preload_en  (preload_en),
    .preload_val (preload_val),
    .pin_oe      (pin_oe),
    .fb_out      (fb_out),
    .cfg         (cfg),
    .reg_q       (reg_q)
);

// File: tb/olmc_cell_test.sv
`timescale 1ns/1ps
module olmc_cell_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       glb_sync = 1'b0, glb_arch = 1'b1, cell_io = 1'b0, cell_pol = 1'b1;
    logic       edge_cell = 1'b0, core_cell = 1'b0;
    logic [7:0] pterm = 8'h00;
    logic       oe_n = 1'b0, pin_in = 1'b0, adj_in = 1'b0;
    logic       preload_en = 1'b0, preload_val = 1'b0;
    logic       pin_out, pin_oe, fb_out;

    int errors = 0;
    int checks = 0;
    bit mq = 1'b0;          // reference register
    bit last_pre = 1'b0;    // last edge was a preload
    bit last_rst = 1'b1;    // register content came from reset

    always #2 clk = ~clk;   // 250 MHz

    olmc_cell uut (
        .clk(clk), .rst_n(rst_n), .glb_sync(glb_sync), .glb_arch(glb_arch),
        .cell_io(cell_io), .cell_pol(cell_pol), .edge_cell(edge_cell),
        .core_cell(core_cell), .pterm(pterm), .oe_n(oe_n), .pin_in(pin_in),
        .adj_in(adj_in), .preload_en(preload_en), .preload_val(preload_val),
        .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        bit    regm, cplx, simp, d, oe, f;
        string t, tf;
        regm = glb_arch && !glb_sync;
        cplx = glb_arch && glb_sync;
        simp = !glb_arch;
        if (!rst_n) begin
            mq = 1'b0;
            last_rst = 1'b1;
            last_pre = 1'b0;
        end
        if (regm && !cell_io) begin
            d = mq; oe = !oe_n; f = !mq;
            t = last_rst ? "R10" : (last_pre ? "R9" : "R2");
            tf = "R3";
        end else if (simp) begin
            d = |pterm; oe = 1'b1; f = core_cell ? 1'b0 : adj_in;
            t = glb_sync ? "R1/R7" : "R7";
            tf = core_cell ? "R8" : "R7";
        end else begin
            d = |pterm[7:1]; oe = pterm[0];
            f = (cplx && edge_cell) ? 1'b0 : pin_in;
            t = cplx ? "R1/R4" : "R4";
            tf = (cplx && edge_cell) ? "R6" : "R4";
        end
        chk({t, "+R5"}, "pin_out", pin_out, cell_pol ? d : !d);
        chk(t, "pin_oe", pin_oe, oe);
        chk(tf, "fb_out", fb_out, f);
    endtask

    // one cycle: inputs already set at a falling edge
    task automatic step();
        #0.5;
        compare();
        @(posedge clk);
        if (!rst_n) begin
            mq = 1'b0; last_rst = 1'b1; last_pre = 1'b0;
        end else if (preload_en) begin
            mq = preload_val; last_rst = 1'b0; last_pre = 1'b1;
        end else begin
            mq = |pterm; last_rst = 1'b0; last_pre = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic set_mode(input bit s, input bit a, input bit io);
        glb_sync = s; glb_arch = a; cell_io = io;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R10: reset state, both polarities
        set_mode(1'b0, 1'b1, 1'b0);
        pterm = 8'hFF;
        cell_pol = 1'b1; step();
        cell_pol = 1'b0; step();
        rst_n = 1'b1;
        // R2: registered output, single-term patterns
        cell_pol = 1'b1;
        pterm = 8'h01; step(); step();
        pterm = 8'h80; oe_n = 1'b1; step(); step();
        pterm = 8'h00; cell_pol = 1'b0; step(); step();
        // R9: preload against the term sum
        cell_pol = 1'b1;
        preload_en = 1'b1; preload_val = 1'b1; pterm = 8'h00; step();
        preload_en = 1'b0; step();
        preload_en = 1'b1; preload_val = 1'b0; pterm = 8'hFF; step();
        preload_en = 1'b0; pterm = 8'h00; step();
        // R4: combinatorial I/O in registered mode
        set_mode(1'b0, 1'b1, 1'b1);
        pterm = 8'h01; pin_in = 1'b1; step();
        pterm = 8'h80; pin_in = 1'b0; step();
        cell_pol = 1'b0; step();
        // R4/R6: complex mode, inner and outer cell
        set_mode(1'b1, 1'b1, 1'b0);
        cell_pol = 1'b1; pin_in = 1'b1; edge_cell = 1'b0; pterm = 8'h41; step();
        edge_cell = 1'b1; step();
        // R7/R8: simple mode
        set_mode(1'b0, 1'b0, 1'b0);
        edge_cell = 1'b0; pterm = 8'h01; adj_in = 1'b1; step();
        core_cell = 1'b1; step();
        core_cell = 1'b0; pterm = 8'h00; cell_pol = 1'b0; step();
        // R1: the other simple encoding
        set_mode(1'b1, 1'b0, 1'b1);
        pterm = 8'h02; cell_pol = 1'b1; adj_in = 1'b0; step();
        // R10: reset dropped between edges
        set_mode(1'b0, 1'b1, 1'b0);
        preload_en = 1'b1; preload_val = 1'b1; step();
        preload_en = 1'b0; pterm = 8'hFF; step();
        rst_n = 1'b0; step();
        rst_n = 1'b1; step();
        // randomized mix of all configurations
        for (int i = 0; i < 3000; i++) begin
            glb_sync    = 1'($urandom);
            glb_arch    = 1'($urandom);
            cell_io     = 1'($urandom);
            cell_pol    = 1'($urandom);
            edge_cell   = 1'($urandom);
            core_cell   = 1'($urandom);
            pterm       = ($urandom % 3 == 0) ? 8'h00 : 8'(1 << ($urandom % 8));
            if ($urandom % 4 == 0) pterm = 8'($urandom);
            oe_n        = 1'($urandom);
            pin_in      = 1'($urandom);
            adj_in      = 1'($urandom);
            preload_en  = ($urandom % 6 == 0);
            preload_val = 1'($urandom);
            rst_n       = ($urandom % 50 != 0);
            step();
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule